// File: doc/BRIEF.md
# Serial Multiply-Accumulate FIR Loudspeaker Crossover

This block is the filter core of a two-way loudspeaker crossover. For each accepted input sample it runs a single multiplier-accumulator over every tap of an odd-length FIR low-pass filter, one tap per clock. The taps are visited from the newest sample in a circular history buffer to the oldest. When the pass ends it presents two results together. The first is the low-pass sum. The second is a complementary high-pass value, formed by subtracting the low-pass sum from the sample that sits at the filter's centre delay.

Each 56-bit product is reduced to the 28-bit data width before it is added. The reduction has two modes, and the caller picks one for each sample. Floor truncation always rounds down, so its error builds into a DC offset that grows with the tap count. Magnitude truncation always rounds toward zero, so its error behaves like crossover distortion around zero. Having both lets the two biases be compared on real material. Coefficients are loaded through a plain write port. A new sample is taken only while the core is idle.

Top module: `fir_xover`

## Requirements
- R1: After reset, busy, out_valid, out_lp and out_hp are all zero.
- R2: A sample accepted on one clock edge produces out_valid high for exactly one cycle, NTAPS edges later. At that point out_lp equals the saturated sum over k = 0..NTAPS-1 of the quantized product of coefficient address k and the sample k inputs old, where k = 0 is the newest sample.
- R3: With trunc_sm = 0, each product of a Q0 sample and a Q27 coefficient is reduced to floor(p / 2^27), rounding toward minus infinity. A coefficient of 2^26 applied to an input of -1 therefore gives -1.
- R4: With trunc_sm = 1, each product is reduced to sign(p)·floor(|p| / 2^27), rounding toward zero. A coefficient of 2^26 applied to an input of -1 therefore gives 0.
- R5: out_hp equals the sample that is (NTAPS-1)/2 inputs old minus out_lp, saturated to the signed 28-bit range.
- R6: The low-pass sum and each single quantized product saturate to the range -2^27 .. 2^27-1; they never wrap.
- R7: busy is high from the accept edge until the edge that raises out_valid. An in_valid pulse seen while busy is high is ignored and does not change any later output.
- R8: A coefficient written through coef_we/coef_addr/coef_wdata while the core is idle is used by the next pass at tap position coef_addr.
- R9: Before NTAPS samples have arrived after reset, the missing older samples count as zero. NTAPS must be odd and at least 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: new sample present |
| in_sample | input | 28 | Signed input sample |
| trunc_sm | input | 1 | Product truncation: 0 floor, 1 toward zero; latched with the sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(NTAPS) | Tap position to write |
| coef_wdata | input | 28 | Signed Q27 coefficient |
| busy | output | 1 | A filter pass is in progress |
| out_valid | output | 1 | One-cycle pulse: new results |
| out_lp | output | 28 | Signed low-pass result |
| out_hp | output | 28 | Signed high-pass (complement) result |

## Verification
The bench aims at the half-LSB negative product. This is where the two truncation modes part ways. A design that swapped the modes, or truncated the magnitude without restoring the sign, would show -1 where 0 is due, or the reverse. Full-scale coefficients and samples push the low-pass sum and the high-pass difference past the 28-bit limits. A design that wrapped there would flip the sign of its output. The bench also pulses in_valid in the middle of a pass and sweeps a long run of samples through the ring. A design that advanced its write pointer on the ignored pulse, read the taps in the wrong order, or took the centre tap from the wrong position would drift away from the bench's model.

// File: rtl/fxo_pkg.sv
package fxo_pkg;
    // Product reduction style chosen per sample
    typedef enum logic {
        TRUNC_FLOOR = 1'b0,  // two's-complement drop of low bits
        TRUNC_MAG   = 1'b1   // drop low bits of magnitude, keep sign
    } trunc_e;
endpackage

// File: rtl/fxo_sat.sv
module fxo_sat #(
    parameter int IW = 30,
    parameter int OW = 28
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam int EXT = IW - OW + 1;
    localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

    logic fits;

    always_comb begin
        fits = (din[IW-1:OW-1] == {EXT{din[OW-1]}});
        if (fits)
            dout = din[OW-1:0];
        else if (din[IW-1])
            dout = MINV;
        else
            dout = MAXV;
    end
endmodule

// File: rtl/fxo_quant.sv
module fxo_quant
    import fxo_pkg::*;
#(
    parameter int DW   = 28,
    parameter int FRAC = 27
) (
    input  logic signed [2*DW-1:0] prod,
    input  trunc_e                 mode,
    output logic signed [DW-1:0]   term
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] floor_v;
    logic signed [PW-1:0] adj_v;
    logic                 frac_nz;

    always_comb begin
        floor_v = prod >>> FRAC;
        frac_nz = |prod[FRAC-1:0];
        adj_v   = floor_v;
        // toward-zero: a negative value with dropped bits moves up by one
        if (mode == TRUNC_MAG && prod[PW-1] && frac_nz)
            adj_v = floor_v + {{(PW-1){1'b0}}, 1'b1};
    end

    fxo_sat #(.IW(PW), .OW(DW)) u_sat (
        .din  (adj_v),
        .dout (term)
    );
endmodule

// File: rtl/fxo_ram.sv
module fxo_ram #(
    parameter int DEPTH      = 401,
    parameter int DW         = 28,
    parameter int AW         = 9,
    parameter bit CLEAR_RST  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    generate
        if (CLEAR_RST) begin : g_clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
                end else if (we) begin
                    mem_q[waddr] <= wdata;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (we) mem_q[waddr] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fir_xover.sv
module fir_xover
    import fxo_pkg::*;
#(
    parameter int DW    = 28,
    parameter int FRAC  = 27,
    parameter int NTAPS = 401,
    localparam int AW   = $clog2(NTAPS),
    localparam int ACC_W = DW + $clog2(NTAPS) + 1,
    localparam int MID  = (NTAPS - 1) / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic                 trunc_sm,
    input  logic                 coef_we,
    input  logic [AW-1:0]        coef_addr,
    input  logic signed [DW-1:0] coef_wdata,
    output logic                 busy,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_lp,
    output logic signed [DW-1:0] out_hp
);
    localparam logic [AW-1:0] LAST = AW'(NTAPS - 1);
    localparam logic [AW-1:0] MIDA = AW'(MID);

    typedef struct packed {
        logic                    running;
        trunc_e                  mode;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           tap;
        logic signed [ACC_W-1:0] acc;
        logic signed [DW-1:0]    mid;
        logic                    valid;
        logic signed [DW-1:0]    lp;
        logic signed [DW-1:0]    hp;
    } state_t;

    state_t s_q, s_d;

    logic                    hist_we;
    logic [DW-1:0]           hist_rdata;
    logic [DW-1:0]           coef_rdata;
    logic signed [DW-1:0]    x_w;
    logic signed [DW-1:0]    c_w;
    logic signed [2*DW-1:0]  prod_w;
    logic signed [DW-1:0]    term_w;
    logic signed [ACC_W-1:0] sum_w;
    logic signed [DW-1:0]    lp_sat_w;
    logic signed [DW-1:0]    mid_w;
    logic signed [DW:0]      diff_w;
    logic signed [DW-1:0]    hp_sat_w;

    // sample history ring, cleared on reset so early taps read zero
    fxo_ram #(.DEPTH(NTAPS), .DW(DW), .AW(AW), .CLEAR_RST(1'b1)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hist_we),
        .waddr (s_q.wptr),
        .wdata (in_sample),
        .raddr (s_q.rd),
        .rdata (hist_rdata)
    );

    // coefficient store, tap k at address k
    fxo_ram #(.DEPTH(NTAPS), .DW(DW), .AW(AW), .CLEAR_RST(1'b0)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_wdata),
        .raddr (s_q.tap),
        .rdata (coef_rdata)
    );

    always_comb begin
        x_w    = $signed(hist_rdata);
        c_w    = $signed(coef_rdata);
        prod_w = x_w * c_w;
    end

    fxo_quant #(.DW(DW), .FRAC(FRAC)) u_quant (
        .prod (prod_w),
        .mode (s_q.mode),
        .term (term_w)
    );

    always_comb begin
        sum_w = s_q.acc + {{(ACC_W-DW){term_w[DW-1]}}, term_w};
    end

    fxo_sat #(.IW(ACC_W), .OW(DW)) u_lp_sat (
        .din  (sum_w),
        .dout (lp_sat_w)
    );

    always_comb begin
        mid_w  = (s_q.tap == MIDA) ? x_w : s_q.mid;
        diff_w = {mid_w[DW-1], mid_w} - {lp_sat_w[DW-1], lp_sat_w};
    end

    fxo_sat #(.IW(DW+1), .OW(DW)) u_hp_sat (
        .din  (diff_w),
        .dout (hp_sat_w)
    );

    // next-state logic
    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        hist_we   = 1'b0;
        if (!s_q.running) begin
            if (in_valid) begin
                hist_we     = 1'b1;
                s_d.running = 1'b1;
                s_d.mode    = trunc_e'(trunc_sm);
                s_d.rd      = s_q.wptr;
                s_d.tap     = '0;
                s_d.acc     = '0;
                s_d.wptr    = (s_q.wptr == LAST) ? '0 : s_q.wptr + 1'b1;
            end
        end else begin
            if (s_q.tap == MIDA) s_d.mid = x_w;
            if (s_q.tap == LAST) begin
                s_d.running = 1'b0;
                s_d.valid   = 1'b1;
                s_d.lp      = lp_sat_w;
                s_d.hp      = hp_sat_w;
            end else begin
                s_d.acc = sum_w;
                s_d.tap = s_q.tap + 1'b1;
                s_d.rd  = (s_q.rd == '0) ? LAST : s_q.rd - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.running;
    assign out_valid = s_q.valid;
    assign out_lp    = s_q.lp;
    assign out_hp    = s_q.hp;

    // ---------------- assertions ----------------
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid);

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);

    assert_ignore_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.wptr));

    assert_floor_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.mode == TRUNC_FLOOR && prod_w < 0) |-> (term_w < 0));

    assert_mag_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.mode == TRUNC_MAG && prod_w < 0) |-> (term_w <= 0));
endmodule

// File: tb/fir_xover_tb.sv
`timescale 1ns/1ps
module fir_xover_tb;
    localparam int N   = 5;
    localparam int MID = (N - 1) / 2;
    localparam int AW  = $clog2(N);
    localparam longint MAXV = (64'sd1 <<< 27) - 1;
    localparam longint MINV = -(64'sd1 <<< 27);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [27:0]   in_sample = '0;
    logic                 trunc_sm = 1'b0;
    logic                 coef_we = 1'b0;
    logic [AW-1:0]        coef_addr = '0;
    logic signed [27:0]   coef_wdata = '0;
    logic                 busy, out_valid;
    logic signed [27:0]   out_lp, out_hp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint hist [N];
    longint coef [N];

    always #4 clk = ~clk;

    fir_xover #(.NTAPS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .trunc_sm(trunc_sm), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .busy(busy), .out_valid(out_valid),
        .out_lp(out_lp), .out_hp(out_hp)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat28(longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic longint quant(longint p, bit mag);
        longint t;
        if (!mag)      t = p >>> 27;
        else if (p < 0) t = -((-p) >>> 27);
        else           t = p >>> 27;
        return sat28(t);
    endfunction

    task automatic load_coefs(longint c0, longint c1, longint c2, longint c3, longint c4);
        longint cv [N];
        cv = '{c0, c1, c2, c3, c4};
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_addr = AW'(k); coef_wdata = 28'(cv[k]);
            coef[k] = cv[k];
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // push one sample, optionally poke in_valid mid-pass, check outputs
    task automatic push(longint x, bit mag, bit poke, string tag);
        longint lp, hp;
        int cycles;
        for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        lp = 0;
        for (int k = 0; k < N; k++) lp += quant(hist[k] * coef[k], mag);
        lp = sat28(lp);
        hp = sat28(hist[MID] - lp);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 28'(x); trunc_sm = mag;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cycles = 0;
        while (!out_valid && cycles < 100) begin
            @(posedge clk); @(negedge clk);
            cycles++;
            if (poke && cycles == 2) begin
                check("R7 busy mid-pass", longint'(busy), 1);
                in_valid = 1'b1; in_sample = 28'h5A5A5A5; trunc_sm = ~mag;
            end
            if (poke && cycles == 3) begin
                in_valid = 1'b0; trunc_sm = mag;
            end
        end
        check({"R2 latency ", tag}, cycles, N);
        check({"R7 busy low at result ", tag}, longint'(busy), 0);
        check({"R2 lp ", tag}, longint'(out_lp), lp);
        check({"R5 hp ", tag}, longint'(out_hp), hp);
        @(negedge clk);
        check({"R2 single pulse ", tag}, longint'(out_valid), 0);
    endtask

    task automatic flush(bit mag);
        for (int i = 0; i < N; i++) push(0, mag, 0, "flush");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R2 actual=hang expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin hist[k] = 0; coef[k] = 0; end
        repeat (3) @(negedge clk);
        check("R1 busy", longint'(busy), 0);
        check("R1 valid", longint'(out_valid), 0);
        check("R1 lp", longint'(out_lp), 0);
        check("R1 hp", longint'(out_hp), 0);
        rst_n = 1'b1;

        // R8/R9: ramp coefficients, impulse into empty history
        load_coefs(1 <<< 20, 2 <<< 20, 3 <<< 20, 4 <<< 20, 5 <<< 20);
        push(128, 0, 0, "R9 impulse");
        check("R9 first lp literal", longint'(out_lp), 1);
        for (int i = 1; i < N; i++) push(0, 0, 0, "R8 tap order");

        // R3/R4 explicit half-LSB case
        load_coefs(1 <<< 26, 0, 0, 0, 0);
        push(-1, 0, 0, "R3 floor");
        check("R3 floor of -0.5", longint'(out_lp), -1);
        push(-1, 1, 0, "R4 mag");
        check("R4 toward zero of -0.5", longint'(out_lp), 0);
        push(1, 0, 0, "R3 pos");
        check("R3 floor of +0.5", longint'(out_lp), 0);

        // near-exhaustive sweep of small inputs, both modes, with pokes
        load_coefs(3 <<< 25, -(5 <<< 24), 7 <<< 23, 1 <<< 26, -(1 <<< 22));
        for (int m = 0; m < 2; m++)
            for (int x = -12; x <= 12; x++)
                push(x, m[0], (x % 4) == 0, m == 0 ? "R3 sweep" : "R4 sweep");

        // large-magnitude sweep
        load_coefs(MAXV, -(1 <<< 25), MINV, 3 <<< 24, -(7 <<< 23));
        for (int i = 0; i < 16; i++)
            push((i % 2 == 0) ? (longint'(i) <<< 22) : -(longint'(i) <<< 22), i[0], 0, "R6 sweep");

        // R6: low-pass saturation both ways
        load_coefs(MAXV, MAXV, MAXV, MAXV, MAXV);
        for (int i = 0; i < N; i++) push(MAXV, 0, 0, "R6 pos");
        check("R6 lp saturates high", longint'(out_lp), MAXV);
        for (int i = 0; i < N; i++) push(MINV, 1, 0, "R6 neg");
        check("R6 lp saturates low", longint'(out_lp), MINV);

        // R6 single-product corner: -1.0 * -2^27
        load_coefs(MINV, 0, 0, 0, 0);
        push(MINV, 0, 0, "R6 product");
        check("R6 product clamp", longint'(out_lp), MAXV);

        // R5: high-pass difference saturates
        load_coefs(0, 0, 0, 0, MINV);
        for (int i = 0; i < N; i++) push(MAXV, 0, 0, "R5 sat");
        check("R5 hp saturates high", longint'(out_hp), MAXV);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule